// File: doc/BRIEF.md
# Polled Receiver Mode Sequencer

This block sequences a duty-cycled radio receiver through four operating modes: sleeping, warming up, checking the incoming bit stream, and receiving. While it sleeps, a down-counter paced by a slow timer tick counts out a programmed sleep length. A fixed warm-up interval follows. An external bit checker then reports a pass or a fail. A pass opens the data-valid gate and puts the receiver in receiving mode.

Two controls decide how receiving ends. The first is a polling-enable pin. While this pin is low the receiver stays awake: an end of data does not drop it back to polling, and an OFF command skips the sleep interval and goes straight to warm-up and a fresh bit check. The second is a noise-disable configuration bit. When it is set, the end of a stream always returns the receiver to polling. When it is clear, the polling-enable pin decides what happens.

Top module: `rx_poll_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `mode` becomes start-up (code 1) and `data_valid` becomes 0. Mode codes are: sleep 0, start-up 1, bit-check 2, receiving 3.
- R2: Start-up counts `STARTUP_TICKS` ticks. On the clock edge after the last of those ticks, the mode changes to bit-check.
- R3: On entry to sleep, the count is loaded from `sleep_len`. After `sleep_len` ticks, the next clock edge moves the mode to start-up. A `sleep_len` of 0 leaves sleep on the clock edge after entry.
- R4: In bit-check, `chk_pass` moves the mode to receiving on the next edge. This holds even when `chk_fail` is high in the same cycle.
- R5: In bit-check, `chk_fail` alone moves the mode to sleep if `poll_en` is high. If `poll_en` is low, the mode stays in bit-check.
- R6: In receiving, `off_cmd` with `poll_en` high moves the mode to sleep.
- R7: In receiving, `off_cmd` with `poll_en` low moves the mode to start-up with no sleep interval. The controller then reaches bit-check after `STARTUP_TICKS` ticks and returns to receiving only on a pass.
- R8: In receiving, `data_end` with `noise_dis` = 0 and `poll_en` = 0 leaves the mode in receiving.
- R9: In receiving, `data_end` with `noise_dis` = 0 and `poll_en` = 1 moves the mode to sleep.
- R10: In receiving, `data_end` with `noise_dis` = 1 moves the mode to sleep whatever the level of `poll_en`.
- R11: `data_valid` is 1 exactly when `mode` is receiving.
- R12: The following inputs have no effect on the mode: `chk_pass` outside bit-check, `off_cmd` and `data_end` outside receiving, and `tick` in bit-check or receiving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer tick strobe, one cycle wide |
| chk_pass | input | 1 | Bit check succeeded strobe |
| chk_fail | input | 1 | Bit check failed strobe |
| data_end | input | 1 | End of received data stream strobe |
| off_cmd | input | 1 | OFF command strobe |
| poll_en | input | 1 | Polling-enable pin level |
| noise_dis | input | 1 | Automatic end-of-stream return to polling |
| sleep_len | input | SLEEP_W | Programmed sleep length in ticks |
| mode | output | 2 | Current mode code |
| data_valid | output | 1 | Data gate, high in receiving |

## Verification
The bench counts ticks through sleep and start-up one tick at a time. It checks the mode just before and just after each interval ends, which catches an off-by-one count in either direction, and it also tries a zero sleep length. Each exit from receiving (OFF command, end of data) is tried under all the relevant combinations of `poll_en` and `noise_dis`. Telling sleep apart from start-up after an OFF command shows whether the sleep is skipped. Strobes given in the wrong mode, and a pass and fail given together, test the input priority and confirm that ignored inputs do nothing.

// File: rtl/rx_poll_pkg.sv
package rx_poll_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP   = 2'd0,
    MODE_STARTUP = 2'd1,
    MODE_BITCHK  = 2'd2,
    MODE_RECV    = 2'd3
  } rx_mode_e;
endpackage

// File: rtl/rx_tick_timer.sv
module rx_tick_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= CNT_W'(RST_VAL);
    else if (load)
      cnt_q <= load_val;
    else if (tick && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R2 R3: each tick removes exactly one from a running count
  assert_tick_decrement_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R3: a load lands the programmed value
  assert_load_value_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/rx_mode_fsm.sv
module rx_mode_fsm
  import rx_poll_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int STARTUP_TICKS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             expired,
  input  logic             chk_pass,
  input  logic             chk_fail,
  input  logic             data_end,
  input  logic             off_cmd,
  input  logic             poll_en,
  input  logic             noise_dis,
  input  logic [CNT_W-1:0] sleep_len,
  output rx_mode_e         mode_q,
  output logic             data_valid_q,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);
  localparam logic [CNT_W-1:0] STARTUP_LOAD = CNT_W'(STARTUP_TICKS);

  rx_mode_e nxt;

  always_comb begin
    nxt = mode_q;
    unique case (mode_q)
      MODE_SLEEP:   if (expired) nxt = MODE_STARTUP;
      MODE_STARTUP: if (expired) nxt = MODE_BITCHK;
      MODE_BITCHK: begin
        if (chk_pass)      nxt = MODE_RECV;
        else if (chk_fail) nxt = poll_en ? MODE_SLEEP : MODE_BITCHK;
      end
      MODE_RECV: begin
        if (off_cmd)
          nxt = poll_en ? MODE_SLEEP : MODE_STARTUP;
        else if (data_end && (noise_dis || poll_en))
          nxt = MODE_SLEEP;
      end
      default: nxt = MODE_STARTUP;
    endcase
  end

  assign load     = (nxt != mode_q) && (nxt == MODE_SLEEP || nxt == MODE_STARTUP);
  assign load_val = (nxt == MODE_SLEEP) ? sleep_len : STARTUP_LOAD;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= MODE_STARTUP;
      data_valid_q <= 1'b0;
    end else begin
      mode_q       <= nxt;
      data_valid_q <= (nxt == MODE_RECV);
    end
  end

  assert_valid_gate_R11: assert property (@(posedge clk) disable iff (rst)
    data_valid_q == (mode_q == MODE_RECV));

  assert_pass_enters_recv_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_BITCHK && chk_pass) |=> (mode_q == MODE_RECV));

  assert_fail_retry_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_BITCHK && !chk_pass && chk_fail && !poll_en) |=> (mode_q == MODE_BITCHK));

  assert_off_skips_sleep_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RECV && off_cmd && !poll_en) |=> (mode_q == MODE_STARTUP));

  assert_stay_awake_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RECV && !off_cmd && data_end && !poll_en && !noise_dis) |=> (mode_q == MODE_RECV));

  assert_sleep_expiry_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SLEEP && expired) |=> (mode_q == MODE_STARTUP));
endmodule

// File: rtl/rx_poll_ctrl.sv
module rx_poll_ctrl
  import rx_poll_pkg::*;
#(
  parameter int SLEEP_W       = 8,
  parameter int STARTUP_TICKS = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               chk_pass,
  input  logic               chk_fail,
  input  logic               data_end,
  input  logic               off_cmd,
  input  logic               poll_en,
  input  logic               noise_dis,
  input  logic [SLEEP_W-1:0] sleep_len,
  output logic [1:0]         mode,
  output logic               data_valid
);
  logic               load;
  logic [SLEEP_W-1:0] load_val;
  logic               expired;
  rx_mode_e           mode_q;

  rx_tick_timer #(.CNT_W(SLEEP_W), .RST_VAL(STARTUP_TICKS)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .tick     (tick),
    .expired  (expired)
  );

  rx_mode_fsm #(.CNT_W(SLEEP_W), .STARTUP_TICKS(STARTUP_TICKS)) i_fsm (
    .clk          (clk),
    .rst          (rst),
    .expired      (expired),
    .chk_pass     (chk_pass),
    .chk_fail     (chk_fail),
    .data_end     (data_end),
    .off_cmd      (off_cmd),
    .poll_en      (poll_en),
    .noise_dis    (noise_dis),
    .sleep_len    (sleep_len),
    .mode_q       (mode_q),
    .data_valid_q (data_valid),
    .load         (load),
    .load_val     (load_val)
  );

  assign mode = mode_q;
endmodule

// File: tb/test_rx_poll_ctrl.sv
module test_rx_poll_ctrl;
  localparam int SW = 8;
  localparam int ST = 3;
  localparam logic [1:0] SLP = 2'd0, STU = 2'd1, BCK = 2'd2, RCV = 2'd3;

  logic clk = 1'b0;
  logic rst, tick, chk_pass, chk_fail, data_end, off_cmd, poll_en, noise_dis;
  logic [SW-1:0] sleep_len;
  logic [1:0] mode;
  logic data_valid;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_poll_ctrl #(.SLEEP_W(SW), .STARTUP_TICKS(ST)) i_rx_poll_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .chk_pass(chk_pass), .chk_fail(chk_fail),
    .data_end(data_end), .off_cmd(off_cmd), .poll_en(poll_en), .noise_dis(noise_dis),
    .sleep_len(sleep_len), .mode(mode), .data_valid(data_valid));

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic [1:0] em, input string tag);
    logic edv;
    edv = (em == RCV);
    checks++;
    if (mode !== em || data_valid !== edv) begin
      errors++;
      $display("FAIL %s: mode=%0d dv=%0d expected mode=%0d dv=%0d", tag, mode, data_valid, em, edv);
    end
  endtask

  task automatic do_tick(); tick = 1'b1; step(); tick = 1'b0; endtask
  task automatic do_pass(); chk_pass = 1'b1; step(); chk_pass = 1'b0; endtask
  task automatic do_fail(); chk_fail = 1'b1; step(); chk_fail = 1'b0; endtask
  task automatic do_off(); off_cmd = 1'b1; step(); off_cmd = 1'b0; endtask
  task automatic do_end(); data_end = 1'b1; step(); data_end = 1'b0; endtask

  task automatic do_reset();
    rst = 1'b1; step(); step(); rst = 1'b0;
  endtask

  task automatic to_bitchk();
    do_reset();
    for (int i = 0; i < ST; i++) do_tick();
    step();
  endtask

  task automatic to_recv();
    to_bitchk();
    do_pass();
  endtask

  task automatic t_reset_startup();
    do_reset();
    chk(STU, "R1 reset state");
    for (int i = 0; i < ST; i++) do_tick();
    chk(STU, "R2 still start-up after last tick");
    step();
    chk(BCK, "R2 bit-check after start-up");
  endtask

  task automatic t_pass();
    to_bitchk();
    chk_fail = 1'b1; do_pass(); chk_fail = 1'b0;
    chk(RCV, "R4 pass wins over fail");
    chk(RCV, "R11 data_valid in receiving");
  endtask

  task automatic t_fail();
    poll_en = 1'b0; to_bitchk(); do_fail();
    chk(BCK, "R5 fail retries with poll_en low");
    poll_en = 1'b1; do_fail();
    chk(SLP, "R5 fail sleeps with poll_en high");
  endtask

  task automatic t_sleep();
    poll_en = 1'b1; sleep_len = 8'd4; to_recv(); do_off();
    chk(SLP, "R6 off with poll_en high");
    for (int i = 0; i < 3; i++) do_tick();
    step();
    chk(SLP, "R3 sleep before last tick");
    do_tick();
    chk(SLP, "R3 sleep at last tick");
    step();
    chk(STU, "R3 start-up after sleep");
    sleep_len = 8'd0; to_recv(); do_off();
    chk(SLP, "R3 zero sleep entered");
    step();
    chk(STU, "R3 zero sleep left after one cycle");
  endtask

  task automatic t_off_awake();
    poll_en = 1'b0; sleep_len = 8'd50; to_recv(); do_off();
    chk(STU, "R7 off with poll_en low skips sleep");
    for (int i = 0; i < ST; i++) do_tick();
    step();
    chk(BCK, "R7 bit-check after start-up");
    do_pass();
    chk(RCV, "R7 receiving after pass");
  endtask

  task automatic t_data_end();
    noise_dis = 1'b0; poll_en = 1'b0; to_recv(); do_end();
    chk(RCV, "R8 stays receiving");
    poll_en = 1'b1; do_end();
    chk(SLP, "R9 poll_en high ends receiving");
    noise_dis = 1'b1; poll_en = 1'b0; to_recv(); do_end();
    chk(SLP, "R10 noise_dis forces polling");
    noise_dis = 1'b0;
  endtask

  task automatic t_ignored();
    do_reset(); do_pass(); do_off(); do_end();
    chk(STU, "R12 strobes ignored in start-up");
    to_bitchk(); do_off(); do_end(); do_tick(); do_tick();
    chk(BCK, "R12 ticks and off ignored in bit-check");
    poll_en = 1'b0; do_pass();
    do_tick(); do_pass(); do_fail();
    chk(RCV, "R12 tick and check strobes ignored in receiving");
  endtask

  initial begin
    rst = 1'b1; tick = 0; chk_pass = 0; chk_fail = 0; data_end = 0; off_cmd = 0;
    poll_en = 1'b1; noise_dis = 1'b0; sleep_len = 8'd4;
    @(negedge clk);
    t_reset_startup();
    t_pass();
    t_fail();
    t_sleep();
    t_off_awake();
    t_data_end();
    t_ignored();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule